// File: doc/BRIEF.md
# Synchronous Channel Unmute Sequencer

This block keeps newly enabled synchronous streaming channels silent until the serial link has been shown to be healthy, then releases them all at once. Each channel has a 3-bit type code and an enable bit. When a synchronous channel's enable rises, its mute output goes high. Control, asynchronous and isochronous channels are never muted here.

A start request launches a fixed check sequence. First the sticky clock-missing status flag is examined. While it reads 1, the block pulses a clear strobe, idles for one cycle and reads the flag again. Once the flag reads 0, the block waits for the link-lock indication. With lock present, it counts frame-boundary pulses. On the fourth pulse it clears every pending mute in one cycle. It then raises a done flag, which stays high until the next start request.

If lock is lost during the frame count, the count is discarded and the block waits for lock again. Clock recovery, lock detection and frame timing all come from outside the block; only their results are inputs.

Top module: `sync_unmute_seq`

## Requirements
- R1: Type code 3'b000 marks a synchronous channel. On the cycle after an enabled synchronous channel's enable is first seen high, its mute output is 1.
- R2: A channel whose type code is 3'b001 (control), 3'b010 (asynchronous), 3'b011 (isochronous) or any other non-zero value never has its mute output set.
- R3: After a start request, if the clock-missing flag reads 0, the block goes straight on to the lock wait and never pulses the clear strobe.
- R4: Each time the check finds the clock-missing flag at 1, the clear strobe is high for exactly one cycle. The flag is read again two cycles after the strobe ends, so strobes for a flag that stays set are three cycles apart.
- R5: While lock is low, frame pulses are not counted, no mute is released and done stays 0.
- R6: Once lock has been seen, the fourth frame pulse that arrives with lock high releases the mutes. Fewer than four pulses release nothing.
- R7: If lock falls during the frame count, the count restarts from zero. After lock returns, four further frame pulses are needed.
- R8: At release, every enabled synchronous channel has its mute cleared in the same cycle that done rises.
- R9: Done stays high until a start request. The cycle after that request, done is 0.
- R10: A disabled channel's mute is 0. A synchronous channel enabled after release is muted again and stays muted until a later run.
- R11: A start request that arrives while a check sequence is running has no effect on the sequence or on its frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run the check sequence |
| clk_missing_i | input | 1 | Sticky clock-missing status flag |
| lock_i | input | 1 | Link lock indication |
| frame_i | input | 1 | One-cycle frame-boundary pulse |
| ch_type_i | input | NUM_CH*TYPE_W | Per-channel type codes, channel i at bits [i*TYPE_W +: TYPE_W] |
| ch_en_i | input | NUM_CH | Per-channel enables |
| clk_missing_clr_o | output | 1 | One-cycle clear strobe for the clock-missing flag |
| mute_o | output | NUM_CH | Per-channel mute controls |
| done_o | output | 1 | Sequence complete, mutes released |

## Verification
A stuck or skipped sequencer state shows up within one cycle as one of three faults: a clear strobe that lasts too long, a strobe with no clock-missing flag, or strobes at the wrong spacing. An off-by-one in the frame counter makes mute fall and done rise one frame early or late. Lock-drop handling and the ignored mid-sequence start expose this fault directly. A faulty per-channel mute bit appears on mute_o on the cycle after the enable or type changes. The bench therefore sweeps sixteen sync/non-sync channel masks through a complete run each.

// File: rtl/sync_unmute_pkg.sv
package sync_unmute_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_CLEAR,
        ST_GAP,
        ST_LOCK,
        ST_SETTLE,
        ST_DONE
    } seq_state_e;

    localparam logic [2:0] CT_SYNC  = 3'b000;
    localparam logic [2:0] CT_CTRL  = 3'b001;
    localparam logic [2:0] CT_ASYNC = 3'b010;
    localparam logic [2:0] CT_ISOC  = 3'b011;

endpackage

// File: rtl/unmute_ctrl.sv
module unmute_ctrl
    import sync_unmute_pkg::*;
#(
    parameter int SETTLE_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clk_missing_i,
    input  logic lock_i,
    input  logic frame_i,
    output logic clr_o,
    output logic release_o,
    output logic done_o
);

    localparam int CNT_W = (SETTLE_FRAMES > 1) ? $clog2(SETTLE_FRAMES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_FRAMES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d    = ctrl_q;
        clr_o     = (ctrl_q.st == ST_CLEAR);
        done_o    = (ctrl_q.st == ST_DONE);
        release_o = 1'b0;
        case (ctrl_q.st)
            ST_IDLE: begin
                if (start_i) ctrl_d.st = ST_CHECK;
            end
            ST_CHECK: begin
                ctrl_d.st = clk_missing_i ? ST_CLEAR : ST_LOCK;
            end
            ST_CLEAR: ctrl_d.st = ST_GAP;
            ST_GAP:   ctrl_d.st = ST_CHECK;
            ST_LOCK: begin
                if (lock_i) begin
                    ctrl_d.st  = ST_SETTLE;
                    ctrl_d.cnt = '0;
                end
            end
            ST_SETTLE: begin
                if (!lock_i) begin
                    ctrl_d.st  = ST_LOCK;
                    ctrl_d.cnt = '0;
                end else if (frame_i) begin
                    if (ctrl_q.cnt == LAST) begin
                        release_o  = 1'b1;
                        ctrl_d.st  = ST_DONE;
                        ctrl_d.cnt = '0;
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (start_i) ctrl_d.st = ST_CHECK;
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.st  <= ST_IDLE;
            ctrl_q.cnt <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/mute_bank.sv
module mute_bank
    import sync_unmute_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int TYPE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*TYPE_W-1:0] ch_type_i,
    input  logic [NUM_CH-1:0]        ch_en_i,
    input  logic                     release_i,
    output logic [NUM_CH-1:0]        mute_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] mute;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_CH-1:0] sync_vec;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_decode
        assign sync_vec[gi] = (ch_type_i[gi*TYPE_W +: TYPE_W] == TYPE_W'(CT_SYNC));
    end

    always_comb begin
        bank_d      = bank_q;
        bank_d.en   = ch_en_i;
        bank_d.mute = ch_en_i & sync_vec
                    & (bank_q.mute | (ch_en_i & ~bank_q.en))
                    & ~{NUM_CH{release_i}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.en   <= '0;
            bank_q.mute <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mute_o = bank_q.mute;

endmodule

// File: rtl/sync_unmute_seq.sv
module sync_unmute_seq #(
    parameter int NUM_CH        = 8,
    parameter int TYPE_W        = 3,
    parameter int SETTLE_FRAMES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     clk_missing_i,
    input  logic                     lock_i,
    input  logic                     frame_i,
    input  logic [NUM_CH*TYPE_W-1:0] ch_type_i,
    input  logic [NUM_CH-1:0]        ch_en_i,
    output logic                     clk_missing_clr_o,
    output logic [NUM_CH-1:0]        mute_o,
    output logic                     done_o
);

    logic release_w;

    unmute_ctrl #(
        .SETTLE_FRAMES(SETTLE_FRAMES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .clk_missing_i(clk_missing_i),
        .lock_i       (lock_i),
        .frame_i      (frame_i),
        .clr_o        (clk_missing_clr_o),
        .release_o    (release_w),
        .done_o       (done_o)
    );

    mute_bank #(
        .NUM_CH(NUM_CH),
        .TYPE_W(TYPE_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_type_i(ch_type_i),
        .ch_en_i  (ch_en_i),
        .release_i(release_w),
        .mute_o   (mute_o)
    );

endmodule

// File: rtl/sync_unmute_seq_chk.sv
module sync_unmute_seq_chk #(
    parameter int NUM_CH = 8,
    parameter int TYPE_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     clk_missing_i,
    input logic                     lock_i,
    input logic                     frame_i,
    input logic [NUM_CH*TYPE_W-1:0] ch_type_i,
    input logic [NUM_CH-1:0]        ch_en_i,
    input logic                     clk_missing_clr_o,
    input logic [NUM_CH-1:0]        mute_o,
    input logic                     done_o
);

    logic [NUM_CH-1:0] sync_mask;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            sync_mask[i] = (ch_type_i[i*TYPE_W +: TYPE_W] == '0);
        end
    end

    assert_nonsync_unmuted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_o & ~$past(sync_mask)) == '0);

    assert_disabled_unmuted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_o & ~$past(ch_en_i)) == '0);

    assert_clear_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_missing_clr_o |=> !clk_missing_clr_o);

    assert_clear_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_missing_clr_o |-> $past(clk_missing_i));

    assert_release_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(lock_i) && $past(frame_i)));

    assert_release_clears_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (mute_o == '0));

    assert_done_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

endmodule

bind sync_unmute_seq sync_unmute_seq_chk #(
    .NUM_CH(NUM_CH),
    .TYPE_W(TYPE_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .clk_missing_i    (clk_missing_i),
    .lock_i           (lock_i),
    .frame_i          (frame_i),
    .ch_type_i        (ch_type_i),
    .ch_en_i          (ch_en_i),
    .clk_missing_clr_o(clk_missing_clr_o),
    .mute_o           (mute_o),
    .done_o           (done_o)
);

// File: tb/tb_sync_unmute_seq.sv
module tb_sync_unmute_seq;

    localparam int N  = 8;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          missing = 1'b0;
    logic          lock = 1'b0;
    logic          frame = 1'b0;
    logic [N*TW-1:0] types = '0;
    logic [N-1:0]  en = '0;
    logic          clr;
    logic [N-1:0]  mute;
    logic          done;

    int errs = 0;
    int checks = 0;
    int clr_seen = 0;
    int k_left = 0;

    always #5 clk = ~clk;

    sync_unmute_seq #(.NUM_CH(N), .TYPE_W(TW), .SETTLE_FRAMES(4)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .clk_missing_i(missing),
        .lock_i(lock), .frame_i(frame), .ch_type_i(types), .ch_en_i(en),
        .clk_missing_clr_o(clr), .mute_o(mute), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // advance one clock; model the sticky flag cleared by the strobe
    task automatic cyc();
        @(negedge clk);
        if (clr) begin
            clr_seen++;
            if (k_left > 0) k_left--;
        end
        missing = (k_left != 0);
    endtask

    task automatic do_frames(input int n);
        for (int f = 0; f < n; f++) begin
            frame = 1'b1; cyc();
            frame = 1'b0; cyc();
        end
    endtask

    function automatic logic [N*TW-1:0] build(input logic [N-1:0] m);
        logic [N*TW-1:0] t;
        for (int i = 0; i < N; i++)
            t[i*TW +: TW] = m[i] ? 3'b000 : 3'(1 + (i % 7));
        return t;
    endfunction

    task automatic rearm(input logic [N-1:0] m);
        en = '0; cyc();
        chk(mute == '0, "R10 disabled mute", 32'(mute), 0);
        types = build(m); en = '1; cyc();
        chk(mute == m, "R1 enable mute", 32'(mute), 32'(m));
        chk((mute & ~m) == '0, "R2 nonsync mute", 32'(mute & ~m), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mute == '0 && done == 1'b0 && clr == 1'b0, "R1 reset state", {mute, done, clr}, 0);
        rst_n = 1'b1;
        cyc();

        // sweep channel masks through a full clean run each
        for (int k = 0; k < 16; k++) begin
            logic [N-1:0] m;
            int clr0;
            m = N'(k * 37);
            lock = 1'b0;
            rearm(m);
            clr0 = clr_seen;
            start = 1'b1; cyc(); start = 1'b0; cyc();
            repeat (3) cyc();
            chk(done == 1'b0 && mute == m, "R5 no lock hold", 32'(mute), 32'(m));
            do_frames(2);
            chk(done == 1'b0 && mute == m, "R5 frames without lock", 32'(mute), 32'(m));
            lock = 1'b1; cyc();
            do_frames(3);
            chk(done == 1'b0 && mute == m, "R6 three frames", 32'(mute), 32'(m));
            frame = 1'b1; cyc(); frame = 1'b0;
            chk(mute == '0, "R8 release all", 32'(mute), 0);
            chk(done == 1'b1, "R6 done on fourth frame", 32'(done), 1);
            chk(clr_seen == clr0, "R3 no clear strobe", 32'(clr_seen - clr0), 0);
            repeat (3) cyc();
            chk(done == 1'b1, "R9 done held", 32'(done), 1);
            start = 1'b1; cyc(); start = 1'b0;
            chk(done == 1'b0, "R9 done drops on start", 32'(done), 0);
            cyc(); cyc(); do_frames(4);
            chk(done == 1'b1, "R9 rerun completes", 32'(done), 1);
        end

        // clock-missing retry loop, flag needs two clears
        begin
            logic [11:0] hist;
            lock = 1'b0;
            rearm(8'h81);
            k_left = 2; missing = 1'b1;
            start = 1'b1; cyc(); start = 1'b0;
            for (int c = 0; c < 12; c++) begin
                cyc();
                hist[c] = clr;
            end
            chk(hist == 12'h009, "R4 strobe pattern", 32'(hist), 32'h009);
            chk(missing == 1'b0, "R4 flag cleared", 32'(missing), 0);
            chk(mute == 8'h81 && done == 1'b0, "R5 still muted", 32'(mute), 32'h81);
            lock = 1'b1; cyc(); do_frames(4);
            chk(mute == '0 && done == 1'b1, "R8 release after retry", 32'(mute), 0);
        end

        // lock drop during frame count
        lock = 1'b0;
        rearm(8'h24);
        start = 1'b1; cyc(); start = 1'b0; lock = 1'b1; cyc(); cyc();
        do_frames(3);
        lock = 1'b0; cyc(); lock = 1'b1; cyc();
        do_frames(3);
        chk(mute == 8'h24 && done == 1'b0, "R7 count restarted", 32'(mute), 32'h24);
        do_frames(1);
        chk(mute == '0 && done == 1'b1, "R7 release after relock", 32'(mute), 0);

        // start during sequence ignored; late enable re-mutes
        rearm(8'hFF);
        start = 1'b1; cyc(); start = 1'b0; cyc(); cyc();
        do_frames(2);
        start = 1'b1; cyc(); start = 1'b0;
        chk(mute == 8'hFF && done == 1'b0, "R11 start ignored", 32'(mute), 32'hFF);
        do_frames(1);
        chk(mute == 8'hFF, "R11 count kept", 32'(mute), 32'hFF);
        do_frames(1);
        chk(mute == '0 && done == 1'b1, "R11 release on fourth", 32'(mute), 0);
        en[2] = 1'b0; cyc(); en[2] = 1'b1; cyc();
        chk(mute == 8'h04 && done == 1'b1, "R10 late enable muted", 32'(mute), 32'h04);
        en[2] = 1'b0; cyc();
        chk(mute == '0, "R10 disable clears", 32'(mute), 0);

        summary();
        $finish;
    end

endmodule